// File: doc/BRIEF.md
# Coprocessor Debug and Single-Step Controller

This block decides, cycle by cycle, whether the instruction pipeline of a small interrupt-driven coprocessor may retire its next instruction. It holds the program counter, the active channel ID and a masked control register that a host reaches over a 16-bit write/read port. The core shows a ready instruction with `ins_valid`, and it flags a break instruction or a taken branch with its target on the same cycle. The controller raises `core_advance` when that instruction may retire.

Debug mode starts in one of two ways: the host writes the debug bit, or a break instruction retires. In debug mode the core is halted, apart from single steps. Each step command lets exactly one instruction retire. While the core is halted, the host may overwrite the program counter and the channel ID, and new channel requests have no effect. Clearing the debug bit resumes execution from the current program counter.

Host registers are selected by `host_sel`: 0 is the control register, 1 is the channel ID, 2 is the program counter, and 3 reads as zero. In the control register, bit 0 is debug, bit 1 is step and bit 2 is break-interrupt enable. Their write masks are bits 8, 9 and 10.

Top module: `dbg_step_ctrl`

## Requirements
- R1: After reset, the control register, the channel ID and the program counter all read 0, and `dbg_active` and `brk_irq` are low.
- R2: A control write changes debug (bit 0), step (bit 1) or break-interrupt enable (bit 2) only when that bit's mask (bit 8, 9 or 10) is 1 in the same write. Bits without their mask set keep their old value.
- R3: A control write of debug=1 with its mask halts the core. From the next cycle `core_advance` is low and the program counter stays unchanged.
- R4: When a break instruction retires, `dbg_active` is set on the next cycle and the program counter keeps the break instruction's address.
- R5: A channel request while running loads `chan_req_id` into the channel ID on the next cycle. A request while halted leaves the channel ID unchanged.
- R6: While halted, a host write to select 1 sets the channel ID, and that value is read back unchanged.
- R7: While halted, a host write to select 2 sets the program counter, and the next step executes from that address. While running, such a write is ignored.
- R8: A step command (step=1 with its mask, while in debug mode) retires exactly one instruction. The program counter moves by 2, or to the target for a taken branch. The step bit then reads 0. A step command given outside debug mode is ignored.
- R9: Writing debug=0 with its mask resumes execution, and the program counter keeps advancing by 2 from its current value.
- R10: When break-interrupt enable is 1, a retiring break instruction produces a one-cycle `brk_irq` pulse on the next cycle. When the enable is 0, no pulse occurs.
- R11: `dbg_active` stays high for as long as the core is halted, until a control write clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe |
| host_sel | input | 2 | Register select: 0 control, 1 channel ID, 2 program counter |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Read data of the selected register, zero-extended |
| ins_valid | input | 1 | Core has an instruction ready to retire |
| ins_brk | input | 1 | The ready instruction is a break instruction |
| ins_taken | input | 1 | The ready instruction is a taken branch |
| ins_target | input | PC_W | Branch target of the ready instruction |
| core_advance | output | 1 | The ready instruction may retire this cycle |
| chan_req | input | 1 | New interrupt channel request |
| chan_req_id | input | CH_W | ID of the requesting channel |
| chan_id | output | CH_W | Active channel ID |
| pc_out | output | PC_W | Program counter |
| dbg_active | output | 1 | Debug status: the core is halted |
| brk_irq | output | 1 | One-cycle interrupt request raised by a break instruction |

## Verification
The properties assume that `ins_brk` and `ins_taken` are never high together. They also assume that the branch and break flags have meaning only while `ins_valid` is high. The single-retire property assumes that no control write lands in the same cycle as a stepped retirement. The stimulus changes inputs only at the falling clock edge. It asserts at most one of the two instruction flags at a time, and it holds each host write for one cycle, placed between retirements.

// File: rtl/dbg_step_pkg.sv
package dbg_step_pkg;
  localparam int HOST_DW  = 16;
  localparam int BIT_DBG  = 0;
  localparam int BIT_STEP = 1;
  localparam int BIT_BIE  = 2;
  localparam int MASK_OFS = 8;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_CHAN = 2'd1,
    SEL_PC   = 2'd2,
    SEL_NONE = 2'd3
  } host_sel_e;
endpackage

// File: rtl/dbg_ctrl_reg.sv
module dbg_ctrl_reg
  import dbg_step_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [HOST_DW-1:0] wdata,
  input  logic               brk_ev,
  input  logic               retire_ev,
  output logic               dbg_q,
  output logic               step_q,
  output logic               bie_q
);
  // a bit is writable only when its mask travels in the same write
  function automatic logic masked(input logic [HOST_DW-1:0] d, input int bitpos);
    return d[MASK_OFS + bitpos];
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dbg_q  <= 1'b0;
      step_q <= 1'b0;
      bie_q  <= 1'b0;
    end else begin
      if (brk_ev)
        dbg_q <= 1'b1;
      else if (wr_en && masked(wdata, BIT_DBG))
        dbg_q <= wdata[BIT_DBG];

      if (retire_ev)
        step_q <= 1'b0;
      else if (wr_en && masked(wdata, BIT_STEP) && dbg_q)
        step_q <= wdata[BIT_STEP];

      if (wr_en && masked(wdata, BIT_BIE))
        bie_q <= wdata[BIT_BIE];
    end
  end
endmodule

// File: rtl/dbg_pc_unit.sv
module dbg_pc_unit #(
  parameter int PC_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [PC_W-1:0] wdata,
  input  logic            retire_ev,
  input  logic            is_brk,
  input  logic            is_taken,
  input  logic [PC_W-1:0] target,
  output logic [PC_W-1:0] pc_q
);
  localparam logic [PC_W-1:0] INSN_BYTES = PC_W'(2);

  function automatic logic [PC_W-1:0] step_pc(
    input logic [PC_W-1:0] pc, input logic brk,
    input logic taken, input logic [PC_W-1:0] tgt);
    if (brk)        return pc;
    else if (taken) return tgt;
    else            return pc + INSN_BYTES;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)         pc_q <= '0;
    else if (wr_en)     pc_q <= wdata;
    else if (retire_ev) pc_q <= step_pc(pc_q, is_brk, is_taken, target);
  end
endmodule

// File: rtl/dbg_chan_unit.sv
module dbg_chan_unit #(
  parameter int CH_W = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            halted,
  input  logic            req,
  input  logic [CH_W-1:0] req_id,
  input  logic            wr_en,
  input  logic [CH_W-1:0] wdata,
  output logic [CH_W-1:0] chan_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)             chan_q <= '0;
    else if (wr_en)         chan_q <= wdata;
    else if (req && !halted) chan_q <= req_id;
  end
endmodule

// File: rtl/dbg_step_ctrl.sv
module dbg_step_ctrl
  import dbg_step_pkg::*;
#(
  parameter int PC_W = 16,
  parameter int CH_W = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_wr,
  input  logic [1:0]         host_sel,
  input  logic [HOST_DW-1:0] host_wdata,
  output logic [HOST_DW-1:0] host_rdata,
  input  logic               ins_valid,
  input  logic               ins_brk,
  input  logic               ins_taken,
  input  logic [PC_W-1:0]    ins_target,
  output logic               core_advance,
  input  logic               chan_req,
  input  logic [CH_W-1:0]    chan_req_id,
  output logic [CH_W-1:0]    chan_id,
  output logic [PC_W-1:0]    pc_out,
  output logic               dbg_active,
  output logic               brk_irq
);
  host_sel_e sel;
  logic dbg_q, step_q, bie_q;
  logic retire_ev, brk_ev, ctrl_wr_ev, chan_wr_ev, pc_wr_ev;
  logic irq_q;

  assign sel          = host_sel_e'(host_sel);
  assign core_advance = !dbg_q || step_q;
  assign retire_ev    = ins_valid && core_advance;
  assign brk_ev       = retire_ev && ins_brk;
  assign ctrl_wr_ev   = host_wr && (sel == SEL_CTRL);
  assign chan_wr_ev   = host_wr && (sel == SEL_CHAN) && dbg_q;
  assign pc_wr_ev     = host_wr && (sel == SEL_PC) && dbg_q;

  dbg_ctrl_reg u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(ctrl_wr_ev), .wdata(host_wdata),
    .brk_ev(brk_ev), .retire_ev(retire_ev),
    .dbg_q(dbg_q), .step_q(step_q), .bie_q(bie_q)
  );

  dbg_pc_unit #(.PC_W(PC_W)) u_pc (
    .clk(clk), .rst_n(rst_n), .wr_en(pc_wr_ev), .wdata(host_wdata[PC_W-1:0]),
    .retire_ev(retire_ev), .is_brk(ins_brk), .is_taken(ins_taken),
    .target(ins_target), .pc_q(pc_out)
  );

  dbg_chan_unit #(.CH_W(CH_W)) u_chan (
    .clk(clk), .rst_n(rst_n), .halted(dbg_q), .req(chan_req),
    .req_id(chan_req_id), .wr_en(chan_wr_ev), .wdata(host_wdata[CH_W-1:0]),
    .chan_q(chan_id)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= brk_ev && bie_q;
  end

  assign brk_irq    = irq_q;
  assign dbg_active = dbg_q;

  always_comb begin
    host_rdata = '0;
    unique case (sel)
      SEL_CTRL: begin
        host_rdata[BIT_DBG]  = dbg_q;
        host_rdata[BIT_STEP] = step_q;
        host_rdata[BIT_BIE]  = bie_q;
      end
      SEL_CHAN: host_rdata[CH_W-1:0] = chan_id;
      SEL_PC:   host_rdata[PC_W-1:0] = pc_out;
      default:  host_rdata = '0;
    endcase
  end
endmodule

// File: rtl/dbg_step_checker.sv
module dbg_step_checker #(
  parameter int PC_W = 16,
  parameter int CH_W = 7
) (
  input logic            clk,
  input logic            rst_n,
  input logic            retire_ev,
  input logic            brk_ev,
  input logic            ins_brk,
  input logic            ins_taken,
  input logic            pc_wr_ev,
  input logic            chan_wr_ev,
  input logic            ctrl_wr_ev,
  input logic            dbg_active,
  input logic            core_advance,
  input logic [PC_W-1:0] pc_out,
  input logic [CH_W-1:0] chan_id,
  input logic            brk_irq
);
  // R4
  a_r4_brk_freezes_pc: assert property (@(posedge clk) disable iff (!rst_n)
    brk_ev && !pc_wr_ev |=> dbg_active && (pc_out == $past(pc_out)));

  // R8
  a_r8_pc_plus_two: assert property (@(posedge clk) disable iff (!rst_n)
    retire_ev && !ins_brk && !ins_taken && !pc_wr_ev |=> pc_out == $past(pc_out) + PC_W'(2));

  // R8
  a_r8_single_retire: assert property (@(posedge clk) disable iff (!rst_n)
    retire_ev && dbg_active && !ctrl_wr_ev |=> !core_advance);

  // R5
  a_r5_chan_held: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_active && !chan_wr_ev |=> $stable(chan_id));

  // R11
  a_r11_halt_held: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_active && !ctrl_wr_ev |=> dbg_active);

  // R10
  a_r10_irq_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    brk_irq |=> !brk_irq);
endmodule

bind dbg_step_ctrl dbg_step_checker #(.PC_W(PC_W), .CH_W(CH_W)) u_dbg_chk (
  .clk(clk), .rst_n(rst_n), .retire_ev(retire_ev), .brk_ev(brk_ev),
  .ins_brk(ins_brk), .ins_taken(ins_taken), .pc_wr_ev(pc_wr_ev),
  .chan_wr_ev(chan_wr_ev), .ctrl_wr_ev(ctrl_wr_ev), .dbg_active(dbg_active),
  .core_advance(core_advance), .pc_out(pc_out), .chan_id(chan_id),
  .brk_irq(brk_irq)
);

// File: tb/dbg_step_ctrl_bench.sv
module dbg_step_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int PC_W = 16;
  localparam int CH_W = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_wr = 1'b0;
  logic [1:0] host_sel = 2'd3;
  logic [15:0] host_wdata = '0;
  logic [15:0] host_rdata;
  logic ins_valid = 1'b1;
  logic ins_brk = 1'b0;
  logic ins_taken = 1'b0;
  logic [PC_W-1:0] ins_target = '0;
  logic core_advance;
  logic chan_req = 1'b0;
  logic [CH_W-1:0] chan_req_id = '0;
  logic [CH_W-1:0] chan_id;
  logic [PC_W-1:0] pc_out;
  logic dbg_active, brk_irq;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbg_step_ctrl #(.PC_W(PC_W), .CH_W(CH_W)) u_dbg_step_ctrl (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_sel(host_sel),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .ins_valid(ins_valid),
    .ins_brk(ins_brk), .ins_taken(ins_taken), .ins_target(ins_target),
    .core_advance(core_advance), .chan_req(chan_req), .chan_req_id(chan_req_id),
    .chan_id(chan_id), .pc_out(pc_out), .dbg_active(dbg_active), .brk_irq(brk_irq)
  );

  typedef struct packed {
    logic [PC_W-1:0] pc;
    logic [CH_W-1:0] ch;
    logic            dbg;
    logic            adv;
    logic            irq;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int n_chk = 0;
  int n_fail = 0;

  // reference state, kept from the requirements
  logic [PC_W-1:0] m_pc = '0;
  logic [CH_W-1:0] m_ch = '0;
  logic m_dbg = 0, m_step = 0, m_bie = 0, m_irq = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // one clock with the given stimulus; pushes the expected outputs
  task automatic tick(input string tag, input logic wr = 0, input logic [1:0] sel = 2'd3,
                      input logic [15:0] wd = 0, input logic brk = 0, input logic tk = 0,
                      input logic [PC_W-1:0] tgt = 0, input logic cr = 0,
                      input logic [CH_W-1:0] cid = 0);
    logic adv, ret, brk_r;
    logic [PC_W-1:0] n_pc;
    logic [CH_W-1:0] n_ch;
    logic n_dbg, n_step, n_bie;
    exp_t e;
    host_wr = wr; host_sel = sel; host_wdata = wd;
    ins_brk = brk; ins_taken = tk; ins_target = tgt;
    chan_req = cr; chan_req_id = cid;
    adv   = !m_dbg || m_step;
    ret   = ins_valid && adv;
    brk_r = ret && brk;
    n_pc = m_pc;
    if (wr && sel == 2'd2 && m_dbg) n_pc = wd[PC_W-1:0];
    else if (ret) n_pc = brk ? m_pc : (tk ? tgt : m_pc + 2);
    n_dbg = m_dbg;
    if (brk_r) n_dbg = 1;
    else if (wr && sel == 2'd0 && wd[8]) n_dbg = wd[0];
    n_step = m_step;
    if (ret) n_step = 0;
    else if (wr && sel == 2'd0 && wd[9] && m_dbg) n_step = wd[1];
    n_bie = m_bie;
    if (wr && sel == 2'd0 && wd[10]) n_bie = wd[2];
    n_ch = m_ch;
    if (wr && sel == 2'd1 && m_dbg) n_ch = wd[CH_W-1:0];
    else if (cr && !m_dbg) n_ch = cid;
    m_irq = brk_r && m_bie;
    m_pc = n_pc; m_ch = n_ch; m_dbg = n_dbg; m_step = n_step; m_bie = n_bie;
    @(posedge clk);
    e.pc = m_pc; e.ch = m_ch; e.dbg = m_dbg; e.adv = !m_dbg || m_step; e.irq = m_irq;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
    host_wr = 0; host_sel = 2'd3; ins_brk = 0; ins_taken = 0; chan_req = 0;
  endtask

  task automatic rd(input string tag, input logic [1:0] sel, input logic [15:0] exp);
    host_sel = sel;
    #1;
    chk(tag, {16'h0, host_rdata}, {16'h0, exp});
    host_sel = 2'd3;
  endtask

  // monitor: pops expected items as results appear
  initial begin
    forever begin
      @(negedge clk);
      if (exp_q.size() > 0) begin
        exp_t  e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(t, 32'({pc_out, chan_id, dbg_active, core_advance, brk_irq}), 32'(e));
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset values
    rd("R1 ctrl", 2'd0, 16'h0000);
    rd("R1 chan", 2'd1, 16'h0000);
    rd("R1 pc",   2'd2, 16'h0000);
    chk("R1 status", {30'h0, dbg_active, brk_irq}, 32'h0);
    rst_n = 1;
    // running: pc + 2 each cycle (R9 run behaviour)
    tick("R9 run");
    tick("R9 run");
    // R5: request accepted while running
    tick("R5 req run", .cr(1), .cid(7'd5));
    // R8: step outside debug ignored
    tick("R8 step outside", .wr(1), .sel(2'd0), .wd(16'h0202));
    rd("R8 step ignored", 2'd0, 16'h0000);
    // R2: debug bit without mask does nothing
    tick("R2 no mask", .wr(1), .sel(2'd0), .wd(16'h0001));
    rd("R2 ctrl", 2'd0, 16'h0000);
    // R2: enable break interrupt with its mask
    tick("R2 bie", .wr(1), .sel(2'd0), .wd(16'h0404));
    rd("R2 bie read", 2'd0, 16'h0004);
    // R7: pc write while running ignored
    tick("R7 run write", .wr(1), .sel(2'd2), .wd(16'h1234));
    // R4 / R10: break instruction
    tick("R4 brk", .brk(1));
    tick("R11 held");
    tick("R11 held");
    // R5: request while halted ignored
    tick("R5 req halted", .cr(1), .cid(7'd9));
    // R6: host channel write
    tick("R6 chan wr", .wr(1), .sel(2'd1), .wd(16'h0033));
    rd("R6 chan read", 2'd1, 16'h0033);
    // R8: single step, plain instruction
    tick("R8 step cmd", .wr(1), .sel(2'd0), .wd(16'h0202));
    tick("R8 step retire");
    tick("R8 no second");
    rd("R8 step cleared", 2'd0, 16'h0005);
    // R8: step on taken branch
    tick("R8 step cmd", .wr(1), .sel(2'd0), .wd(16'h0202));
    tick("R8 branch", .tk(1), .tgt(16'h0100));
    // R7: pc override then step
    tick("R7 pc wr", .wr(1), .sel(2'd2), .wd(16'h0040));
    rd("R7 pc read", 2'd2, 16'h0040);
    tick("R7 step cmd", .wr(1), .sel(2'd0), .wd(16'h0202));
    tick("R7 step from new pc");
    // R10: step into a break with interrupt enabled
    tick("R10 step cmd", .wr(1), .sel(2'd0), .wd(16'h0202));
    tick("R10 brk step", .brk(1));
    tick("R10 pulse ends");
    // R2: disable interrupt, R9: resume
    tick("R2 bie off", .wr(1), .sel(2'd0), .wd(16'h0400));
    tick("R9 resume", .wr(1), .sel(2'd0), .wd(16'h0100));
    tick("R9 run");
    tick("R9 run");
    // R10: break without enable gives no pulse
    tick("R10 no irq", .brk(1));
    tick("R11 held");
    tick("R9 resume", .wr(1), .sel(2'd0), .wd(16'h0100));
    tick("R9 run");
    // R3: host halt
    tick("R3 halt", .wr(1), .sel(2'd0), .wd(16'h0101));
    tick("R3 halted");
    tick("R3 halted");
    rd("R3 ctrl", 2'd0, 16'h0001);
    tick("R9 resume", .wr(1), .sel(2'd0), .wd(16'h0100));
    tick("R9 run");
    @(negedge clk);
    #1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule